// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block multiplies two 18-bit operands and folds each product into a 52-bit running total. The total is a 36-bit product width plus 16 guard bits, so about 2^16 full-scale products can be summed before the total leaves its range. Each operand carries its own signed/unsigned selector. The product is treated as signed whenever either operand is signed, and it is kept at full precision.

The block can add or subtract every product into the total, and the choice may change on any cycle. A load strobe starts a new sum with no dead cycle: the product, or its negation when subtracting, replaces the feedback value. An overflow flag pulses for one cycle on the edge where the total wraps. An optional register stage sits between the multiplier and the accumulator, and the accumulator register drives the result output directly. A single enable freezes the whole block. An active-low asynchronous clear zeroes every register.

Top module: `macUnit`

## Requirements
- R1: With both sign selects low and addSub high, each enabled update adds the unsigned product opA*opB to accOut, modulo 2^52.
- R2: aSigned (bSigned) high makes opA (opB) a two's complement value. The product is signed when either select is high, and it is sign-extended into the total.
- R3: addSub low subtracts the product from the total instead of adding it. The choice can change on every cycle.
- R4: loadNew high with addSub high writes the product into accOut and discards the previous total, with no idle cycle before or after.
- R5: loadNew high with addSub low writes the negated product into accOut.
- R6: While en is low, accOut holds its value and ovf is low on the following cycle.
- R7: ovf goes high on the edge that writes a wrapped total. When both selects are low, this means the exact result is below 0 or above 2^52-1. Otherwise it means the exact result is outside the signed 52-bit range. A load counts as a result from a zero feedback value.
- R8: ovf is a single-cycle pulse. It returns low on the next edge unless that edge also wraps.
- R9: With PIPE=1 (the default), operands and controls sampled on one enabled edge reach accOut on the next enabled edge. With PIPE=0 they reach it on the same edge.
- R10: rstN low clears accOut, ovf and the pipeline stage. The first enabled update after reset therefore adds a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous clear, active low |
| en | input | 1 | Clock enable for all registers |
| opA | input | 18 | First operand |
| opB | input | 18 | Second operand |
| aSigned | input | 1 | opA is two's complement when high |
| bSigned | input | 1 | opB is two's complement when high |
| addSub | input | 1 | 1 adds the product, 0 subtracts it |
| loadNew | input | 1 | 1 replaces the feedback value with zero (starts a new sum) |
| accOut | output | 52 | Registered accumulator total |
| ovf | output | 1 | One-cycle wrap pulse |

## Verification
Each error in the product or in the control stage enters the total and stays there, so accOut is compared on every enabled edge against a bench model that tracks the pending pipeline stage. A fault in signedness, in the subtract path or in load handling shows up at the ports one edge after its effect reaches the accumulator. A fault in the wrap detector shows up as a wrong ovf pulse on that same edge. A directed run of about 32,000 full-scale unsigned additions brings the total close to the signed limit, and a single signed product then pushes it over. This exercises the signed overflow path as well as the unsigned one.

// File: rtl/macPkg.sv
package macPkg;
  typedef struct packed {
    logic load;
    logic sub;
    logic sgn;
  } accCtl_t;
endpackage

// File: rtl/macMult.sv
module macMult #(
  parameter int A_W   = 18,
  parameter int B_W   = 18,
  parameter int PIPE  = 1,
  localparam int PRODW = A_W + B_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    en,
  input  logic [A_W-1:0]          opA,
  input  logic [B_W-1:0]          opB,
  input  logic                    aSigned,
  input  logic                    bSigned,
  output logic signed [PRODW-1:0] prod
);
  logic signed [A_W:0]       extA;
  logic signed [B_W:0]       extB;
  logic signed [PRODW-1:0]   prodNow;

  always_comb begin
    extA    = {aSigned & opA[A_W-1], opA};
    extB    = {bSigned & opB[B_W-1], opB};
    prodNow = extA * extB;
  end

  generate
    if (PIPE != 0) begin : g_pipe
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)   prod <= '0;
        else if (en) prod <= prodNow;
      end
    end else begin : g_comb
      always_comb prod = prodNow;
    end
  endgenerate

  // R2: two unsigned operands never give a negative product
  assert_unsigned_nonneg_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!aSigned && !bSigned) |-> !prodNow[PRODW-1]);
endmodule

// File: rtl/macCtrl.sv
module macCtrl #(
  parameter int PIPE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             addSub,
  input  logic             loadNew,
  input  logic             aSigned,
  input  logic             bSigned,
  output macPkg::accCtl_t  ctl
);
  macPkg::accCtl_t ctlNow;

  always_comb begin
    ctlNow.load = loadNew;
    ctlNow.sub  = ~addSub;
    ctlNow.sgn  = aSigned | bSigned;
  end

  generate
    if (PIPE != 0) begin : g_pipe
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)   ctl <= '0;
        else if (en) ctl <= ctlNow;
      end
    end else begin : g_comb
      always_comb ctl = ctlNow;
    end
  endgenerate
endmodule

// File: rtl/macAccum.sv
module macAccum #(
  parameter int PRODW = 38,
  parameter int ACC_W = 52
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    en,
  input  logic signed [PRODW-1:0] prod,
  input  macPkg::accCtl_t         ctl,
  output logic [ACC_W-1:0]        accOut,
  output logic                    ovf
);
  localparam int EXT_W = ACC_W + 1;

  logic [EXT_W-1:0] prodExt;
  logic [EXT_W-1:0] feedBack;
  logic [EXT_W-1:0] sumNext;
  logic             wrapNow;

  always_comb begin
    prodExt  = {{(EXT_W-PRODW){prod[PRODW-1]}}, prod};
    if (ctl.load)     feedBack = '0;
    else if (ctl.sgn) feedBack = {accOut[ACC_W-1], accOut};
    else              feedBack = {1'b0, accOut};
    sumNext  = ctl.sub ? (feedBack - prodExt) : (feedBack + prodExt);
    wrapNow  = ctl.sgn ? (sumNext[EXT_W-1] ^ sumNext[ACC_W-1]) : sumNext[EXT_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOut <= '0;
      ovf    <= 1'b0;
    end else begin
      if (en) accOut <= sumNext[ACC_W-1:0];
      ovf <= en & wrapNow;
    end
  end

  // R6: disabled cycle freezes the total and drops the flag
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(accOut) && !ovf));

  // R4: a load while adding leaves exactly the product in the total
  assert_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctl.load && !ctl.sub) |=> (accOut == $past(prodExt[ACC_W-1:0])));

  // R7: an unsigned add wraps exactly when the total gets smaller
  assert_uns_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (en && !ctl.load && !ctl.sub && !ctl.sgn) |=> (ovf == (accOut < $past(accOut))));
endmodule

// File: rtl/macUnit.sv
module macUnit #(
  parameter int A_W   = 18,
  parameter int B_W   = 18,
  parameter int GUARD = 16,
  parameter int PIPE  = 1,
  localparam int PRODW = A_W + B_W + 2,
  localparam int ACC_W = A_W + B_W + GUARD
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  input  logic             aSigned,
  input  logic             bSigned,
  input  logic             addSub,
  input  logic             loadNew,
  output logic [ACC_W-1:0] accOut,
  output logic             ovf
);
  logic signed [PRODW-1:0] prod;
  macPkg::accCtl_t         ctl;

  macMult #(.A_W(A_W), .B_W(B_W), .PIPE(PIPE)) u_mult (
    .clk(clk), .rstN(rstN), .en(en), .opA(opA), .opB(opB),
    .aSigned(aSigned), .bSigned(bSigned), .prod(prod)
  );

  macCtrl #(.PIPE(PIPE)) u_ctrl (
    .clk(clk), .rstN(rstN), .en(en), .addSub(addSub), .loadNew(loadNew),
    .aSigned(aSigned), .bSigned(bSigned), .ctl(ctl)
  );

  macAccum #(.PRODW(PRODW), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rstN(rstN), .en(en), .prod(prod), .ctl(ctl),
    .accOut(accOut), .ovf(ovf)
  );
endmodule

// File: tb/macUnit_tb.sv
module macUnit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0;
  logic [17:0] opA = '0;
  logic [17:0] opB = '0;
  logic        aSigned = 1'b0;
  logic        bSigned = 1'b0;
  logic        addSub = 1'b1;
  logic        loadNew = 1'b0;
  logic [51:0] accOut;
  logic        ovf;

  int checks = 0;
  int fails  = 0;

  // bench model state (PIPE=1: one pending stage)
  logic [51:0] mAcc = '0;
  logic        mOvf = 1'b0;
  longint      pProd = 0;
  logic        pSub = 1'b0;
  logic        pLoad = 1'b0;
  logic        pSgn = 1'b0;

  macUnit u_dut (
    .clk(clk), .rstN(rstN), .en(en), .opA(opA), .opB(opB),
    .aSigned(aSigned), .bSigned(bSigned), .addSub(addSub), .loadNew(loadNew),
    .accOut(accOut), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic longint opVal(input logic [17:0] v, input logic s);
    return s ? longint'($signed(v)) : longint'(v);
  endfunction

  task automatic check(input string tag);
    checks++;
    if (accOut !== mAcc || ovf !== mOvf) begin
      fails++;
      $display("FAIL %s accOut=%h ovf=%b expected accOut=%h ovf=%b", tag, accOut, ovf, mAcc, mOvf);
    end
  endtask

  task automatic modelEdge(input logic e, input logic [17:0] a, input logic [17:0] b,
                           input logic as, input logic bs, input logic add, input logic ld);
    longint view;
    longint exact;
    if (!e) begin
      mOvf = 1'b0;
      return;
    end
    view  = pSgn ? longint'($signed(mAcc)) : longint'({12'b0, mAcc});
    exact = pLoad ? 64'sd0 : view;
    exact = pSub ? exact - pProd : exact + pProd;
    if (pSgn) mOvf = (exact < -64'sh0008_0000_0000_0000) || (exact >= 64'sh0008_0000_0000_0000);
    else      mOvf = (exact < 0) || (exact > 64'sh000F_FFFF_FFFF_FFFF);
    mAcc  = exact[51:0];
    pProd = opVal(a, as) * opVal(b, bs);
    pSub  = ~add;
    pLoad = ld;
    pSgn  = as | bs;
  endtask

  task automatic step(input logic e, input logic [17:0] a, input logic [17:0] b,
                      input logic as, input logic bs, input logic add, input logic ld,
                      input string tag, input bit doCheck);
    @(negedge clk);
    en = e; opA = a; opB = b; aSigned = as; bSigned = bs; addSub = add; loadNew = ld;
    @(posedge clk);
    #1;
    modelEdge(e, a, b, as, bs, add, ld);
    if (doCheck) check(tag);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    #(CLK_PERIOD*2 + 1);
    check("R10");                                     // reset state
    @(negedge clk);
    rstN = 1'b1;

    // R10: first update after reset adds the cleared pipeline product
    step(1, 18'd3, 18'd5, 0, 0, 1, 1, "R10", 1);
    // R9: loaded product shows one enabled edge later
    step(1, 18'd2, 18'd2, 0, 0, 1, 0, "R9", 1);       // expect 15 now (load of 3*5)
    step(1, 18'd0, 18'd0, 0, 0, 1, 0, "R1", 1);       // 15+4 = 19
    // R5: negated load, signed operand
    step(1, 18'd7, 18'd1, 1, 0, 0, 1, "R5", 1);
    step(1, 18'h3FFFD, 18'd4, 1, 0, 1, 0, "R5", 1);   // acc = -7
    step(1, 18'd0, 18'd0, 1, 0, 1, 0, "R2", 1);       // -7 + (-3*4) = -19
    // R2: both signed, negative times negative
    step(1, 18'h3FFFE, 18'h3FFFB, 1, 1, 1, 0, "R2", 1);
    step(1, 18'd0, 18'd0, 1, 1, 1, 0, "R2", 1);       // -19 + 10 = -9
    // R6: enable low holds everything
    step(0, 18'd123, 18'd456, 0, 0, 0, 1, "R6", 1);
    step(0, 18'd999, 18'd999, 1, 1, 1, 1, "R6", 1);
    // R7/R8: unsigned underflow then single-cycle pulse
    step(1, 18'd0, 18'd0, 0, 0, 1, 1, "R4", 1);
    step(1, 18'd1, 18'd1, 0, 0, 0, 0, "R4", 1);       // acc = 0
    step(1, 18'd0, 18'd0, 0, 0, 1, 0, "R7", 1);       // 0 - 1 wraps, ovf
    if (mOvf !== 1'b1) begin checks++; fails++; $display("FAIL R7 model ovf=%b expected=1", mOvf); end
    step(1, 18'd1, 18'd1, 0, 0, 1, 0, "R8", 1);       // 2^52-1 + 0, ovf drops
    step(1, 18'd0, 18'd0, 0, 0, 1, 0, "R7", 1);       // 2^52-1 + 1 carries out

    // R3: constrained random mix of add/sub/load/signedness
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], 18'($urandom), 18'($urandom), r[2], r[3], r[4],
           (r[7:5] == 3'd0), "R3", 1);
    end

    // R7: signed overflow after a long unsigned run near full scale
    step(1, 18'h3FFFF, 18'h3FFFF, 0, 0, 1, 1, "R7", 1);
    for (int i = 0; i < 32767; i++)
      step(1, 18'h3FFFF, 18'h3FFFF, 0, 0, 1, 0, "R1", 1);
    step(1, 18'h20000, 18'h20000, 1, 1, 1, 0, "R1", 1);
    step(1, 18'd0, 18'd0, 0, 0, 1, 0, "R7", 1);
    if (mOvf !== 1'b1) begin checks++; fails++; $display("FAIL R7 model signed ovf=%b expected=1", mOvf); end
    step(1, 18'd0, 18'd0, 0, 0, 1, 0, "R8", 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule